// File: doc/BRIEF.md
# Card Memory-Space Decoder with Indirect Attribute Access

This block is the host-facing target logic of a removable-card peripheral. The host drives a one-cycle strobe for each transfer and selects attribute or common memory, or IO space. The block decodes the access and returns a byte. Attribute memory holds a small read-only card-information table and a bank of 8-bit configuration registers. Only even byte addresses carry data. Any location that is odd, unused or not allowed in the current mode reads back 0xFF.

A static strap picks one of two modes. In direct-only mode the host reads the table and the registers straight out of attribute memory, and common memory does not exist. In local-bus mode, direct attribute memory shows only a short link table, which tells the host that indirect access is available. Three byte registers in a 16-byte window at the bottom of common memory then give full access to attribute space: an address-low register, an address-high register and a data register. This uses only four host address bits.

IO transfers go straight through to an attached 8-bit register port, with no wait state. A bit in the option register gates them.

Top module: `card_space_decoder`

## Requirements
- R1: After reset, host_rdata is 0xFF. All configuration registers and both window address registers are 0.
- R2: Any attribute address with bit 0 set reads 0xFF. A write to such an address, whether direct or through the data register, changes nothing.
- R3: With lb_mode low, every common-memory read returns 0xFF. Common-memory writes change no state.
- R4: With lb_mode high, the window registers sit in common memory: address-low at 0x00, address-high at 0x02, data at 0x04. Both address registers read back what was written. Common offsets 0x06–0x0E, every odd offset, and every offset at or above 0x10 read 0xFF.
- R5: A read or write of the data register acts on the attribute address formed by the low 10 bits of {address-high, address-low}. It follows the same rules as a direct attribute access in direct-only mode.
- R6: The main table occupies even attribute addresses from 0x000 up. Its bytes, in order, are 21 02 02 00 1A 05 01 03 00 02 01 FF. Every other even address below 0x200 reads 0xFF. The table is read directly when lb_mode is low and through the data register when lb_mode is high.
- R7: With lb_mode high, direct attribute reads at even addresses 0x000, 0x002, 0x004, 0x006 return 80 02 49 41. Every other direct attribute address reads 0xFF. Direct attribute writes are ignored in this mode.
- R8: The configuration registers sit at attribute 0x200, 0x202, 0x204 and 0x206 and are 8-bit read/write. Other even addresses from 0x208 to 0x3FE read 0xFF and ignore writes.
- R9: Writes to table addresses (below 0x200) are ignored.
- R10: Bit 0 of the register at 0x200 enables IO. While it is 0, IO reads return 0xFF and io_rd_o/io_wr_o stay low. While it is 1, io_rd_o and io_wr_o follow io_rd and io_wr in the same cycle, with io_addr = host_addr[2:0] and io_wdata = host_wdata.
- R11: Read data appears on host_rdata on the clock edge that samples the read strobe, and holds until the next read. An enabled IO read captures io_rdata in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lb_mode | input | 1 | Strap: 1 selects local-bus mode (indirect window), 0 selects direct-only mode |
| attr_sel | input | 1 | Memory space select: 1 attribute, 0 common |
| mem_rd | input | 1 | Memory read strobe, one cycle |
| mem_wr | input | 1 | Memory write strobe, one cycle |
| io_rd | input | 1 | IO read strobe, one cycle |
| io_wr | input | 1 | IO write strobe, one cycle |
| host_addr | input | 10 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data |
| io_rd_o | output | 1 | Gated IO read strobe to the register port |
| io_wr_o | output | 1 | Gated IO write strobe to the register port |
| io_addr | output | 3 | IO register address |
| io_wdata | output | 8 | IO write data |
| io_rdata | input | 8 | IO read data from the register port |

## Verification
The bench targets odd attribute addresses in both paths. A design that drops the bit-0 check would return table or register bytes there, or let an odd write hit the option register.

It probes common memory in direct-only mode and above the window in local-bus mode. A decoder that ignores the strap or the window limit would expose the address registers outside their place.

It also checks three behaviours that a careless design gets wrong:
- The indirect path must reach both the table and the registers. A design that truncates the high address byte would alias register reads onto the table.
- Direct writes in local-bus mode must be refused.
- IO must stay blocked until the enable bit is written. An ungated port would leak strobes while the card is unconfigured.

// File: rtl/card_space_decoder.sv
module card_space_decoder #(
  parameter int ATTR_W = 10,
  parameter int IO_W   = 3,
  parameter int NREG   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lb_mode,
  input  logic              attr_sel,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [ATTR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              io_rd_o,
  output logic              io_wr_o,
  output logic [IO_W-1:0]   io_addr,
  output logic [7:0]        io_wdata,
  input  logic [7:0]        io_rdata
);

  localparam int WIN_SPAN = 16;
  localparam logic [ATTR_W-1:0] WIN_LO   = ATTR_W'(0);
  localparam logic [ATTR_W-1:0] WIN_HI   = ATTR_W'(2);
  localparam logic [ATTR_W-1:0] WIN_DATA = ATTR_W'(4);

  logic [7:0]        cfg_q [NREG];
  logic [NREG*8-1:0] cfg_flat;
  logic [7:0]        ind_lo_q, ind_hi_q;
  logic [ATTR_W-1:0] ind_addr;
  logic [ATTR_W-1:0] wr_addr;
  logic              attr_we, cfg_hit;
  logic              io_en;
  logic [7:0]        com_val;

  function automatic logic [7:0] main_cis(input logic [ATTR_W-2:0] idx);
    case (int'(idx))
      0: return 8'h21;  1: return 8'h02;  2: return 8'h02;  3: return 8'h00;
      4: return 8'h1A;  5: return 8'h05;  6: return 8'h01;  7: return 8'h03;
      8: return 8'h00;  9: return 8'h02; 10: return 8'h01;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] link_cis(input logic [ATTR_W-1:0] a);
    if (a[0]) return 8'hFF;
    case (int'(a[ATTR_W-1:1]))
      0: return 8'h80;  1: return 8'h02;  2: return 8'h49;  3: return 8'h41;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] attr_read(input logic [ATTR_W-1:0] a,
                                           input logic [NREG*8-1:0] regs);
    if (a[0]) return 8'hFF;
    if (!a[ATTR_W-1]) return main_cis(a[ATTR_W-2:1]);
    if (int'(a[ATTR_W-2:1]) < NREG) return regs[int'(a[ATTR_W-2:1])*8 +: 8];
    return 8'hFF;
  endfunction

  assign ind_addr = ATTR_W'({ind_hi_q, ind_lo_q});
  assign io_en    = cfg_q[0][0];

  assign io_rd_o  = io_rd & io_en;
  assign io_wr_o  = io_wr & io_en;
  assign io_addr  = host_addr[IO_W-1:0];
  assign io_wdata = host_wdata;

  assign attr_we = mem_wr & ((attr_sel & ~lb_mode) |
                             (~attr_sel & lb_mode & (host_addr == WIN_DATA)));
  assign wr_addr = attr_sel ? host_addr : ind_addr;
  assign cfg_hit = ~wr_addr[0] & wr_addr[ATTR_W-1] & (int'(wr_addr[ATTR_W-2:1]) < NREG);

  always_comb begin
    com_val = 8'hFF;
    if (lb_mode && host_addr < ATTR_W'(WIN_SPAN) && !host_addr[0]) begin
      if (host_addr == WIN_LO)        com_val = ind_lo_q;
      else if (host_addr == WIN_HI)   com_val = ind_hi_q;
      else if (host_addr == WIN_DATA) com_val = attr_read(ind_addr, cfg_flat);
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_cfg
    assign cfg_flat[i*8 +: 8] = cfg_q[i];
    always_ff @(posedge clk) begin
      if (!rst_n)
        cfg_q[i] <= 8'h00;
      else if (attr_we && cfg_hit && int'(wr_addr[ATTR_W-2:1]) == i)
        cfg_q[i] <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ind_lo_q <= 8'h00;
      ind_hi_q <= 8'h00;
    end else if (mem_wr && !attr_sel && lb_mode) begin
      if (host_addr == WIN_LO) ind_lo_q <= host_wdata;
      if (host_addr == WIN_HI) ind_hi_q <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      host_rdata <= 8'hFF;
    else if (mem_rd)
      host_rdata <= !attr_sel ? com_val :
                    lb_mode   ? link_cis(host_addr) : attr_read(host_addr, cfg_flat);
    else if (io_rd)
      host_rdata <= io_en ? io_rdata : 8'hFF;
  end

endmodule

// File: rtl/card_space_decoder_chk.sv
module card_space_decoder_chk #(
  parameter int ATTR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lb_mode,
  input logic              attr_sel,
  input logic              mem_rd,
  input logic              io_rd,
  input logic [ATTR_W-1:0] host_addr,
  input logic [7:0]        host_rdata,
  input logic [7:0]        io_rdata,
  input logic              io_en
);

  p_odd_attr_ff_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && attr_sel && host_addr[0]) |=> host_rdata == 8'hFF);

  p_direct_common_ff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !attr_sel && !lb_mode) |=> host_rdata == 8'hFF);

  p_above_window_ff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !attr_sel && host_addr >= ATTR_W'(16)) |=> host_rdata == 8'hFF);

  p_io_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !mem_rd && !io_en) |=> host_rdata == 8'hFF);

  p_io_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !mem_rd && io_en) |=> host_rdata == $past(io_rdata));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd && !io_rd) |=> $stable(host_rdata));

endmodule

bind card_space_decoder card_space_decoder_chk #(.ATTR_W(ATTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lb_mode(lb_mode), .attr_sel(attr_sel),
  .mem_rd(mem_rd), .io_rd(io_rd), .host_addr(host_addr),
  .host_rdata(host_rdata), .io_rdata(io_rdata), .io_en(io_en)
);

// File: tb/tb_card_space_decoder.sv
module tb_card_space_decoder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lb_mode = 1'b0, attr_sel = 1'b0;
  logic       mem_rd = 1'b0, mem_wr = 1'b0, io_rd = 1'b0, io_wr = 1'b0;
  logic [9:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata, io_wdata, io_rdata;
  logic       io_rd_o, io_wr_o;
  logic [2:0] io_addr;

  always #2.5 clk = ~clk;

  assign io_rdata = {5'b10100, io_addr};

  card_space_decoder dut (
    .clk(clk), .rst_n(rst_n), .lb_mode(lb_mode), .attr_sel(attr_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .io_rd_o(io_rd_o), .io_wr_o(io_wr_o), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata)
  );

  int    n_checks = 0, n_fail = 0, cycles = 0;
  string cur_req = "R1";
  bit    done = 0;

  int cis_tab[$] = '{8'h21, 8'h02, 8'h02, 8'h00, 8'h1A, 8'h05, 8'h01, 8'h03, 8'h00, 8'h02, 8'h01, 8'hFF};
  int link_tab[$] = '{8'h80, 8'h02, 8'h49, 8'h41};
  int m_cfg[4];
  int m_lo, m_hi, m_rd;

  function automatic int m_attr(int a);
    if (a % 2 != 0) return 255;
    if (a < 512) return (a / 2 < cis_tab.size()) ? cis_tab[a / 2] : 255;
    if ((a - 512) / 2 < 4) return m_cfg[(a - 512) / 2];
    return 255;
  endfunction

  function automatic void m_attr_wr(int a, int d);
    if (a % 2 == 0 && a >= 512 && (a - 512) / 2 < 4) m_cfg[(a - 512) / 2] = d;
  endfunction

  function automatic int m_common(int a);
    if (!lb_mode || a >= 16 || a % 2 != 0) return 255;
    if (a == 0) return m_lo;
    if (a == 2) return m_hi;
    if (a == 4) return m_attr((m_hi * 256 + m_lo) % 1024);
    return 255;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = '{0, 0, 0, 0}; m_lo = 0; m_hi = 0; m_rd = 255;
    end else begin
      int a;
      a = int'(host_addr);
      if (mem_rd) begin
        if (!attr_sel) m_rd = m_common(a);
        else if (lb_mode) m_rd = (a % 2 == 0 && a / 2 < link_tab.size()) ? link_tab[a / 2] : 255;
        else m_rd = m_attr(a);
      end else if (io_rd) begin
        m_rd = (m_cfg[0] % 2 == 1) ? (8'hA0 | (a % 8)) : 255;
      end
      if (mem_wr) begin
        if (attr_sel && !lb_mode) m_attr_wr(a, int'(host_wdata));
        else if (!attr_sel && lb_mode) begin
          if (a == 0) m_lo = int'(host_wdata);
          else if (a == 2) m_hi = int'(host_wdata);
          else if (a == 4) m_attr_wr((m_hi * 256 + m_lo) % 1024, int'(host_wdata));
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      bit en;
      en = (m_cfg[0] % 2 == 1);
      n_checks++;
      if (int'(host_rdata) != m_rd) begin
        n_fail++;
        $display("FAIL %s: host_rdata actual %02h expected %02h (t=%0t)", cur_req, host_rdata, m_rd[7:0], $time);
      end
      n_checks++;
      if (io_rd_o !== (io_rd && en) || io_wr_o !== (io_wr && en)) begin
        n_fail++;
        $display("FAIL R10: io strobes actual rd=%b wr=%b expected rd=%b wr=%b", io_rd_o, io_wr_o, io_rd && en, io_wr && en);
      end
      if (io_wr && en) begin
        n_checks++;
        if (io_addr !== host_addr[2:0] || io_wdata !== host_wdata) begin
          n_fail++;
          $display("FAIL R10: io addr/data actual %0h/%02h expected %0h/%02h", io_addr, io_wdata, host_addr[2:0], host_wdata);
        end
      end
    end
  end

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      report();
    end
  end

  task automatic op(bit rd, bit wr, bit iorw, bit attr, int a, int d = 0);
    attr_sel = attr; host_addr = 10'(a); host_wdata = 8'(d);
    mem_rd = rd && !iorw; mem_wr = wr && !iorw;
    io_rd = rd && iorw;   io_wr = wr && iorw;
    @(posedge clk); #1;
    mem_rd = 0; mem_wr = 0; io_rd = 0; io_wr = 0;
  endtask

  task automatic rd_a(int a);         op(1, 0, 0, 1, a);    endtask
  task automatic wr_a(int a, int d);  op(0, 1, 0, 1, a, d); endtask
  task automatic rd_c(int a);         op(1, 0, 0, 0, a);    endtask
  task automatic wr_c(int a, int d);  op(0, 1, 0, 0, a, d); endtask
  task automatic rd_io(int a);        op(1, 0, 1, 0, a);    endtask
  task automatic wr_io(int a, int d); op(0, 1, 1, 0, a, d); endtask
  task automatic ind_rd(int a);  wr_c(0, a % 256); wr_c(2, a / 256); rd_c(4); endtask
  task automatic ind_wr(int a, int d); wr_c(0, a % 256); wr_c(2, a / 256); wr_c(4, d); endtask

  task automatic do_reset(bit mode);
    rst_n = 0; lb_mode = mode;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cur_req = "R1";
    repeat (2) @(posedge clk);
    #1;
  endtask

  initial begin
    // Direct-only mode
    do_reset(0);
    cur_req = "R6";
    for (int i = 0; i < 14; i++) rd_a(2 * i);
    rd_a(10'h1FE);
    cur_req = "R2";
    rd_a(10'h001); rd_a(10'h201); wr_a(10'h201, 8'h55); rd_a(10'h200);
    cur_req = "R8";
    wr_a(10'h202, 8'h5A); wr_a(10'h204, 8'h3C); wr_a(10'h206, 8'hC3);
    rd_a(10'h202); rd_a(10'h204); rd_a(10'h206);
    wr_a(10'h208, 8'h99); rd_a(10'h208); rd_a(10'h3FE);
    cur_req = "R9";
    wr_a(10'h000, 8'h00); rd_a(10'h000); wr_a(10'h004, 8'h77); rd_a(10'h004);
    cur_req = "R3";
    rd_c(0); rd_c(4); rd_c(10'h020);
    wr_c(0, 8'h02); wr_c(2, 8'h02); wr_c(4, 8'h01); rd_c(0); rd_a(10'h200);
    cur_req = "R10";
    rd_io(3); wr_io(5, 8'hE7);
    wr_a(10'h200, 8'h01); rd_io(3); wr_io(5, 8'hE7); rd_io(6);
    cur_req = "R11";
    rd_a(10'h002); repeat (3) @(posedge clk); #1; rd_io(1); repeat (2) @(posedge clk); #1;

    // Local-bus mode
    do_reset(1);
    cur_req = "R7";
    for (int i = 0; i < 6; i++) rd_a(2 * i);
    rd_a(10'h003); rd_a(10'h200); wr_a(10'h200, 8'h01); rd_a(10'h200);
    cur_req = "R4";
    wr_c(0, 8'h34); wr_c(2, 8'h12); rd_c(0); rd_c(2);
    rd_c(6); rd_c(14); rd_c(1); rd_c(3); rd_c(16); rd_c(10'h3FE);
    cur_req = "R5";
    ind_rd(10'h200); ind_rd(10'h0000 + 10'h1FE);
    cur_req = "R6";
    for (int i = 0; i < 13; i++) ind_rd(2 * i);
    cur_req = "R2";
    ind_rd(10'h001); ind_wr(10'h201, 8'h01); ind_rd(10'h200);
    cur_req = "R8";
    ind_wr(10'h200, 8'h01); ind_rd(10'h200);
    ind_wr(10'h206, 8'h77); ind_rd(10'h206); ind_wr(10'h20A, 8'h11); ind_rd(10'h20A);
    cur_req = "R9";
    ind_wr(10'h002, 8'hAA); ind_rd(10'h002);
    cur_req = "R10";
    rd_io(2); wr_io(7, 8'h3D);
    cur_req = "R3";
    wr_a(10'h000, 8'h00); rd_c(4);
    repeat (3) @(posedge clk); #1;
    report();
  end

endmodule